// File: doc/BRIEF.md
# Prioritizing Interrupt Controller with Timed Sort

The block gathers 96 or 128 level-sensitive interrupt sources (a parameter), grouped in banks of 32, and drives one interrupt line to a processor. Each source can be masked per bit and carries a 6-bit priority. A global threshold shuts out sources whose priority is not high enough. Software talks to the block over a simple 32-bit register bus. Reads are combinational. A write takes effect on the clock edge at which select and write-enable are high.

Whenever an unmasked, qualifying source is pending, a sorting engine latches the current winner. It then spends a fixed number of cycles before it publishes a result. At the end of that window it checks the winner again. If the winner has changed in the meantime (the source dropped, or a mask write picked another one), the result is marked spurious. The interrupt line stays high until software acknowledges through the control register. The engine then returns to idle and sorts again if anything is still pending.

The sorting engine has three states. IDLE goes to SORT when a candidate exists (transition "launch"). SORT goes to HOLD when the cycle counter reaches its last value ("publish"). HOLD goes back to IDLE on an acknowledge ("release"). A soft reset forces IDLE from any state ("flush"). A second machine handles soft reset. RUN goes to BUSY on a soft-reset write ("start"), and BUSY returns to RUN after a fixed count ("finish").

Top module: `prio_intc`

## Requirements
- R1: After reset every source is masked, `irq_out` is 0 and stays 0 while sources are active, the status register (0x014) bit 0 reads 1, and the revision register (0x000) reads 0x21 (major in bits 7:4, minor in bits 3:0).
- R2: For bank b, writing to 0x088+0x20*b clears the mask bits where the data has a 1, and writing to 0x08C+0x20*b sets them. Zero bits change nothing. The mask reads back at 0x084+0x20*b, where 1 means masked.
- R3: The pending register of bank b at 0x098+0x20*b reads the sources that are active and unmasked, whatever the threshold.
- R4: With a qualifying source first sampled at clock edge E0, `irq_out` is still 0 after edge E0+9 and is 1 after edge E0+10 (a 10-cycle sort).
- R5: The level register of source n at 0x100+4*n holds its priority in bits 5:0, where 0 is the highest priority. The lowest value wins, and a tie goes to the lower source number.
- R6: The threshold register at 0x068 (bits 7:0, reset 0xFF) lets a source take part in sorting only when its priority is strictly below the threshold.
- R7: While `irq_out` is 1, the sorted register at 0x040 reads the winner number in bits 6:0. Bits 31:7 are 0 for a valid result and all 1 for a spurious one.
- R8: The result is spurious when the best candidate at the end of the sort is not the source latched at its start. This covers a source that drops and a mask write that changes the outcome.
- R9: `irq_out` stays 1 until a write to the control register (0x048) with bit 0 set, and writing 0 there has no effect. After the acknowledge, a source that is still pending starts a new full sort.
- R10: Writing bit 1 of the configuration register (0x010) starts a soft reset. Status bit 0 reads 0 for 4 cycles, then 1. Masks, levels, threshold and the other settings return to their reset values, and `irq_out` is held low.
- R11: Configuration bit 0 (autoidle), protection bit 0 (0x04C) and idle bits 1:0 (0x050, functional-idle and turbo) read back what was written.
- R12: With 96 sources there are 3 banks, so source 95 is the top bit of bank 2 and the bank-3 mask address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_src | input | NUM_SRC | Level-sensitive interrupt sources |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write enable (with bus_sel) |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when not selected |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
On every cycle the assertions check these properties: `irq_out` holds until an acknowledge and drops right after one; each rising edge of `irq_out` comes at the end of a full-length sort; mask-set and mask-clear writes touch exactly the written 1 bits; and `irq_out` stays low through a soft reset. Only the bench scenarios can show which source wins under priority ties and the threshold, and how results turn spurious when a source drops or a mask write happens mid-sort. The same holds for the exact cycle at which the interrupt appears, the re-sort after an acknowledge, and register values after a soft reset.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
    localparam int unsigned ADDR_W      = 12;
    localparam int unsigned DATA_W      = 32;
    localparam int unsigned BANK_W      = 32;
    localparam int unsigned PRIO_W      = 6;
    localparam int unsigned THR_W       = 8;
    localparam int unsigned BANK_STRIDE = 32;

    localparam logic [ADDR_W-1:0] A_REV    = 12'h000;
    localparam logic [ADDR_W-1:0] A_SYSCFG = 12'h010;
    localparam logic [ADDR_W-1:0] A_STATUS = 12'h014;
    localparam logic [ADDR_W-1:0] A_SORTED = 12'h040;
    localparam logic [ADDR_W-1:0] A_CTRL   = 12'h048;
    localparam logic [ADDR_W-1:0] A_PROT   = 12'h04C;
    localparam logic [ADDR_W-1:0] A_IDLE   = 12'h050;
    localparam logic [ADDR_W-1:0] A_THRESH = 12'h068;
    localparam logic [ADDR_W-1:0] A_MASK0  = 12'h084;
    localparam logic [ADDR_W-1:0] A_MCLR0  = 12'h088;
    localparam logic [ADDR_W-1:0] A_MSET0  = 12'h08C;
    localparam logic [ADDR_W-1:0] A_PEND0  = 12'h098;
    localparam logic [ADDR_W-1:0] A_LEVEL0 = 12'h100;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SORT,
        ST_HOLD
    } sort_state_t;

    typedef enum logic {
        RS_RUN,
        RS_BUSY
    } rst_state_t;
endpackage

// File: rtl/prio_intc_bank.sv
module prio_intc_bank
    import prio_intc_pkg::*;
#(
    parameter int unsigned BANK_IDX = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [BANK_W-1:0]        src,
    output logic [BANK_W-1:0]        pend_o,
    output logic [BANK_W*PRIO_W-1:0] prio_o,
    output logic [DATA_W-1:0]        rdata
);
    localparam int unsigned IDX_W = $clog2(BANK_W);
    localparam logic [ADDR_W-1:0] MASK_A = A_MASK0 + ADDR_W'(BANK_STRIDE * BANK_IDX);
    localparam logic [ADDR_W-1:0] MCLR_A = A_MCLR0 + ADDR_W'(BANK_STRIDE * BANK_IDX);
    localparam logic [ADDR_W-1:0] MSET_A = A_MSET0 + ADDR_W'(BANK_STRIDE * BANK_IDX);
    localparam logic [ADDR_W-1:0] PEND_A = A_PEND0 + ADDR_W'(BANK_STRIDE * BANK_IDX);
    localparam logic [ADDR_W-8:0] LVL_PAGE = A_LEVEL0[ADDR_W-1:7] + (ADDR_W-7)'(BANK_IDX);

    logic [BANK_W-1:0] mask_q;
    logic [PRIO_W-1:0] prio_q [BANK_W];
    logic              lvl_hit;
    logic [IDX_W-1:0]  lvl_idx;

    assign lvl_hit = (addr[ADDR_W-1:7] == LVL_PAGE);
    assign lvl_idx = addr[IDX_W+1:2];
    assign pend_o  = src & ~mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (clr) begin
            mask_q <= '1;
        end else if (wr_en) begin
            if (addr == MASK_A)      mask_q <= wdata[BANK_W-1:0];
            else if (addr == MSET_A) mask_q <= mask_q | wdata[BANK_W-1:0];
            else if (addr == MCLR_A) mask_q <= mask_q & ~wdata[BANK_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < BANK_W; i++) prio_q[i] <= '0;
        end else if (clr) begin
            for (int i = 0; i < BANK_W; i++) prio_q[i] <= '0;
        end else if (wr_en && lvl_hit) begin
            prio_q[lvl_idx] <= wdata[PRIO_W-1:0];
        end
    end

    genvar g;
    generate
        for (g = 0; g < BANK_W; g++) begin : g_pack
            assign prio_o[g*PRIO_W +: PRIO_W] = prio_q[g];
        end
    endgenerate

    always_comb begin
        rdata = '0;
        if (addr == MASK_A)      rdata = mask_q;
        else if (addr == PEND_A) rdata = pend_o;
        else if (lvl_hit)        rdata = {{(DATA_W-PRIO_W){1'b0}}, prio_q[lvl_idx]};
    end

    // R2: set writes leave every written 1 bit masked
    assert_mask_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr && addr == MSET_A) |=> ((mask_q & $past(wdata[BANK_W-1:0])) == $past(wdata[BANK_W-1:0])));
    // R2: clear writes leave every written 1 bit unmasked
    assert_mask_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr && addr == MCLR_A) |=> ((mask_q & $past(wdata[BANK_W-1:0])) == '0));
    // R2: zero bits of a set/clear write keep their old value
    assert_mask_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr && (addr == MSET_A || addr == MCLR_A)) |=>
        ((mask_q & ~$past(wdata[BANK_W-1:0])) == ($past(mask_q) & ~$past(wdata[BANK_W-1:0]))));
endmodule

// File: rtl/prio_intc_sorter.sv
module prio_intc_sorter
    import prio_intc_pkg::*;
#(
    parameter int unsigned NUM_SRC     = 96,
    parameter int unsigned SORT_CYCLES = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic [NUM_SRC-1:0]        cand,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    input  logic                      ack,
    output logic                      irq_o,
    output logic                      spur_o,
    output logic [$clog2(NUM_SRC)-1:0] win_o
);
    localparam int unsigned ID_W  = $clog2(NUM_SRC);
    localparam int unsigned CNT_W = $clog2(SORT_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SORT_CYCLES - 1);

    sort_state_t       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [ID_W-1:0]   win_q;
    logic              spur_q;
    logic              best_vld;
    logic [ID_W-1:0]   best_id;
    logic [PRIO_W-1:0] best_pr;

    // priority search: strict compare keeps the lower number on ties
    always_comb begin
        best_vld = 1'b0;
        best_id  = '0;
        best_pr  = '1;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (cand[i] && (!best_vld || prio_flat[i*PRIO_W +: PRIO_W] < best_pr)) begin
                best_vld = 1'b1;
                best_id  = ID_W'(i);
                best_pr  = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (best_vld)          state_d = ST_SORT;
            ST_SORT: if (cnt_q == CNT_LAST) state_d = ST_HOLD;
            ST_HOLD: if (ack)               state_d = ST_IDLE;
            default:                        state_d = ST_IDLE;
        endcase
        if (clr) state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            win_q  <= '0;
            spur_q <= 1'b0;
        end else if (clr) begin
            cnt_q  <= '0;
            win_q  <= '0;
            spur_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (best_vld) win_q <= best_id;
                end
                ST_SORT: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == CNT_LAST) spur_q <= !(best_vld && best_id == win_q);
                end
                ST_HOLD: cnt_q <= '0;
                default: cnt_q <= '0;
            endcase
        end
    end

    always_comb begin
        irq_o  = (state_q == ST_HOLD);
        spur_o = spur_q;
        win_o  = win_q;
    end

    // R9: the request holds until acknowledged
    assert_hold_until_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ack && !clr) |=> irq_o);
    // R9: an acknowledge releases the request at once
    assert_ack_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && ack) |=> !irq_o);
    // R4: the request only rises at the end of a full sort window
    assert_sort_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(state_q) == ST_SORT && $past(cnt_q) == CNT_LAST));
endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import prio_intc_pkg::*;
#(
    parameter int unsigned NUM_SRC     = 96,
    parameter int unsigned SORT_CYCLES = 10,
    parameter int unsigned RST_CYCLES  = 4,
    parameter logic [7:0]  REVISION    = 8'h21
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_src,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [11:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq_out
);
    localparam int unsigned NUM_BANK = NUM_SRC / BANK_W;
    localparam int unsigned ID_W     = $clog2(NUM_SRC);
    localparam int unsigned RCNT_W   = $clog2(RST_CYCLES);
    localparam logic [RCNT_W-1:0] RCNT_LAST = RCNT_W'(RST_CYCLES - 1);

    logic                      wr_en;
    logic                      clr;
    logic                      soft_go;
    logic                      ack;
    rst_state_t                rs_q, rs_d;
    logic [RCNT_W-1:0]         rcnt_q;
    logic                      autoidle_q;
    logic                      prot_q;
    logic [1:0]                idle_q;
    logic [THR_W-1:0]          thresh_q;
    logic [NUM_SRC-1:0]        pend;
    logic [NUM_SRC-1:0]        cand;
    logic [NUM_SRC*PRIO_W-1:0] prio_flat;
    logic [DATA_W-1:0]         bank_rd [NUM_BANK];
    logic                      irq_w;
    logic                      spur_w;
    logic [ID_W-1:0]           win_w;
    logic [DATA_W-1:0]         sorted_val;
    logic [DATA_W-1:0]         rd_mux;

    assign wr_en   = bus_sel && bus_we;
    assign soft_go = wr_en && bus_addr == A_SYSCFG && bus_wdata[1];
    assign clr     = (rs_q == RS_BUSY);
    assign ack     = wr_en && bus_addr == A_CTRL && bus_wdata[0] && !clr;

    // soft reset sequencer
    always_comb begin
        rs_d = rs_q;
        unique case (rs_q)
            RS_RUN:  if (soft_go)            rs_d = RS_BUSY;
            RS_BUSY: if (rcnt_q == RCNT_LAST) rs_d = RS_RUN;
            default:                         rs_d = RS_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= RS_RUN;
        else        rs_q <= rs_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            rcnt_q <= '0;
        else if (rs_q == RS_BUSY) rcnt_q <= rcnt_q + 1'b1;
        else                   rcnt_q <= '0;
    end

    // global settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            autoidle_q <= 1'b0;
            prot_q     <= 1'b0;
            idle_q     <= '0;
            thresh_q   <= '1;
        end else if (clr) begin
            autoidle_q <= 1'b0;
            prot_q     <= 1'b0;
            idle_q     <= '0;
            thresh_q   <= '1;
        end else if (wr_en) begin
            unique case (bus_addr)
                A_SYSCFG: autoidle_q <= bus_wdata[0];
                A_PROT:   prot_q     <= bus_wdata[0];
                A_IDLE:   idle_q     <= bus_wdata[1:0];
                A_THRESH: thresh_q   <= bus_wdata[THR_W-1:0];
                default:  ;
            endcase
        end
    end

    genvar b;
    generate
        for (b = 0; b < NUM_BANK; b++) begin : g_bank
            prio_intc_bank #(.BANK_IDX(b)) u_bank (
                .clk    (clk),
                .rst_n  (rst_n),
                .clr    (clr),
                .wr_en  (wr_en),
                .addr   (bus_addr),
                .wdata  (bus_wdata),
                .src    (irq_src[b*BANK_W +: BANK_W]),
                .pend_o (pend[b*BANK_W +: BANK_W]),
                .prio_o (prio_flat[b*BANK_W*PRIO_W +: BANK_W*PRIO_W]),
                .rdata  (bank_rd[b])
            );
        end
    endgenerate

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            cand[i] = pend[i] && ({{(THR_W-PRIO_W){1'b0}}, prio_flat[i*PRIO_W +: PRIO_W]} < thresh_q);
        end
    end

    prio_intc_sorter #(
        .NUM_SRC     (NUM_SRC),
        .SORT_CYCLES (SORT_CYCLES)
    ) u_sorter (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .cand      (cand),
        .prio_flat (prio_flat),
        .ack       (ack),
        .irq_o     (irq_w),
        .spur_o    (spur_w),
        .win_o     (win_w)
    );

    always_comb begin
        if (!irq_w)      sorted_val = '1;
        else if (spur_w) sorted_val = {25'h1FF_FFFF, 7'(win_w)};
        else             sorted_val = {25'h0, 7'(win_w)};
    end

    always_comb begin
        rd_mux = '0;
        unique case (bus_addr)
            A_REV:    rd_mux = {24'h0, REVISION};
            A_SYSCFG: rd_mux = {31'h0, autoidle_q};
            A_STATUS: rd_mux = {31'h0, rs_q == RS_RUN};
            A_SORTED: rd_mux = sorted_val;
            A_PROT:   rd_mux = {31'h0, prot_q};
            A_IDLE:   rd_mux = {30'h0, idle_q};
            A_THRESH: rd_mux = {{(DATA_W-THR_W){1'b0}}, thresh_q};
            default:  rd_mux = '0;
        endcase
        for (int k = 0; k < NUM_BANK; k++) rd_mux = rd_mux | bank_rd[k];
    end

    assign bus_rdata = bus_sel ? rd_mux : '0;
    assign irq_out   = irq_w;

    // R10: the request line is quiet once a soft reset has taken hold
    assert_quiet_soft_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && $past(clr)) |-> !irq_out);
    // R10: soft reset ends after its fixed count
    assert_soft_reset_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && rcnt_q == RCNT_LAST) |=> !clr);
endmodule

// File: tb/prio_intc_tb.sv
module prio_intc_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 96;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] irq_src = '0;
    logic            bus_sel = 1'b0;
    logic            bus_we = 1'b0;
    logic [11:0]     bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            irq_out;

    int total = 0;
    int bad = 0;
    logic [31:0] exp_q [$];

    prio_intc #(.NUM_SRC(NSRC)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_src   (irq_src),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    // driver side of the scoreboard
    task automatic expect_sorted(input logic [31:0] v);
        exp_q.push_back(v);
    endtask

    // monitor side: wait for the request, read the result, compare with the queue head
    task automatic service(input string tag);
        logic [31:0] v;
        logic [31:0] e;
        int waited = 0;
        while (!irq_out && waited < 40) begin
            @(negedge clk);
            waited++;
        end
        rd(12'h040, v);
        if (exp_q.size() == 0) begin
            check({tag, " (no expected item)"}, v, 32'hDEAD_BEEF);
        end else begin
            e = exp_q.pop_front();
            check({tag, " irq_out"}, {31'h0, irq_out}, 32'h1);
            check(tag, v, e);
        end
    endtask

    task automatic quiet(input string tag, input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
        check(tag, {31'h0, irq_out}, 32'h0);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        check("R1 irq_out after reset", {31'h0, irq_out}, 32'h0);
        rd_chk("R1 status", 12'h014, 32'h1);
        rd_chk("R1 revision", 12'h000, 32'h21);
        rd_chk("R1 mask bank0", 12'h084, 32'hFFFF_FFFF);
        rd_chk("R1 mask bank2", 12'h0C4, 32'hFFFF_FFFF);
        @(negedge clk) irq_src[3] = 1'b1;
        quiet("R1 masked source stays silent", 14);
        rd_chk("R3 masked source not pending", 12'h098, 32'h0);

        // R2 mask clear/set, R3 pending
        wr(12'h088, 32'h0000_0008);
        rd_chk("R2 mask clear", 12'h084, 32'hFFFF_FFF7);
        rd_chk("R3 pending bank0", 12'h098, 32'h0000_0008);
        wr(12'h08C, 32'h0);
        wr(12'h088, 32'h0);
        rd_chk("R2 zero writes no effect", 12'h084, 32'hFFFF_FFF7);
        expect_sorted(32'd3);
        service("R7 sorted src3");
        @(negedge clk) irq_src[3] = 1'b0;
        wr(12'h048, 32'h1);
        check("R9 ack releases", {31'h0, irq_out}, 32'h0);
        quiet("R9 no re-sort when idle", 14);

        // R4 sort timing
        @(negedge clk) irq_src[3] = 1'b1;
        repeat (10) @(posedge clk);
        @(negedge clk) check("R4 low at E0+9", {31'h0, irq_out}, 32'h0);
        @(posedge clk);
        @(negedge clk) check("R4 high at E0+10", {31'h0, irq_out}, 32'h1);
        expect_sorted(32'd3);
        service("R4 result");
        wr(12'h048, 32'h0);
        check("R9 zero write no ack", {31'h0, irq_out}, 32'h1);
        wr(12'h048, 32'h1);
        check("R9 ack drop", {31'h0, irq_out}, 32'h0);
        repeat (10) @(posedge clk);
        @(negedge clk);
        repeat (2) @(posedge clk);
        @(negedge clk) check("R9 re-sort after ack", {31'h0, irq_out}, 32'h1);
        expect_sorted(32'd3);
        service("R9 re-sort result");
        irq_src[3] = 1'b0;
        wr(12'h048, 32'h1);

        // R5 priority and ties
        wr(12'h0A8, 32'hFFFF_FFFF);
        wr(12'h100 + 4*40, 32'd5);
        wr(12'h100 + 4*45, 32'd2);
        wr(12'h100 + 4*50, 32'd2);
        rd_chk("R5 level readback", 12'h100 + 4*45, 32'd2);
        @(negedge clk) begin irq_src[40] = 1'b1; irq_src[45] = 1'b1; irq_src[50] = 1'b1; end
        expect_sorted(32'd45);
        expect_sorted(32'd50);
        expect_sorted(32'd40);
        service("R5 best priority low id");
        irq_src[45] = 1'b0;
        wr(12'h048, 32'h1);
        service("R5 next tie member");
        irq_src[50] = 1'b0;
        wr(12'h048, 32'h1);
        service("R5 lowest priority last");
        irq_src[40] = 1'b0;
        wr(12'h048, 32'h1);

        // R6 threshold
        rd_chk("R6 threshold reset", 12'h068, 32'hFF);
        wr(12'h068, 32'd3);
        @(negedge clk) irq_src[40] = 1'b1;
        quiet("R6 prio 5 blocked by threshold 3", 14);
        rd_chk("R3 pending ignores threshold", 12'h0B8, 32'h0000_0100);
        @(negedge clk) irq_src[45] = 1'b1;
        expect_sorted(32'd45);
        service("R6 prio 2 passes");
        irq_src[45] = 1'b0;
        wr(12'h048, 32'h1);
        quiet("R6 still blocked", 14);
        wr(12'h068, 32'hFF);
        expect_sorted(32'd40);
        service("R6 threshold raised");
        irq_src[40] = 1'b0;
        wr(12'h048, 32'h1);

        // R8 spurious by source drop
        @(negedge clk) irq_src[3] = 1'b1;
        repeat (3) @(negedge clk);
        irq_src[3] = 1'b0;
        expect_sorted(32'hFFFF_FF83);
        service("R8 source dropped spurious");
        wr(12'h048, 32'h1);

        // R8 spurious by mask change
        wr(12'h0AC, 32'h0004_0000);
        @(negedge clk) begin irq_src[40] = 1'b1; irq_src[50] = 1'b1; end
        @(negedge clk);
        wr(12'h0A8, 32'h0004_0000);
        expect_sorted(32'hFFFF_FFA8);
        service("R8 mask change spurious");
        irq_src[40] = 1'b0;
        irq_src[50] = 1'b0;
        wr(12'h048, 32'h1);
        quiet("R8 idle after ack", 14);

        // R11 plain settings
        wr(12'h04C, 32'h1);
        rd_chk("R11 protection", 12'h04C, 32'h1);
        wr(12'h050, 32'h3);
        rd_chk("R11 idle bits", 12'h050, 32'h3);
        wr(12'h010, 32'h1);
        rd_chk("R11 autoidle", 12'h010, 32'h1);

        // R10 soft reset
        wr(12'h068, 32'h10);
        wr(12'h010, 32'h2);
        rd_chk("R10 status busy", 12'h014, 32'h0);
        repeat (4) @(posedge clk);
        rd_chk("R10 status done", 12'h014, 32'h1);
        rd_chk("R10 mask restored", 12'h0A4, 32'hFFFF_FFFF);
        rd_chk("R10 threshold restored", 12'h068, 32'hFF);
        rd_chk("R10 level restored", 12'h100 + 4*45, 32'h0);
        rd_chk("R10 protection restored", 12'h04C, 32'h0);
        rd_chk("R10 autoidle restored", 12'h010, 32'h0);

        // R12 size: top source lives in bank 2, no bank 3
        wr(12'h0C8, 32'h8000_0000);
        rd_chk("R12 bank2 mask", 12'h0C4, 32'h7FFF_FFFF);
        rd_chk("R12 no bank3", 12'h0E4, 32'h0);
        @(negedge clk) irq_src[95] = 1'b1;
        expect_sorted(32'd95);
        service("R12 source 95");
        irq_src[95] = 1'b0;
        wr(12'h048, 32'h1);

        check("scoreboard drained", exp_q.size(), 32'd0);
        finish_run();
    end
endmodule